// File: doc/BRIEF.md
# Calibrated Second-Pulse Generator

This block turns a free-running 32768 Hz oscillator clock into a one-second timebase. A down-counter reloads at the end of every second and produces a pulse one oscillator cycle wide in the final cycle of that second. A second-index counter runs from 0 to 59 and wraps. A square wave at 1 Hz, derived from the same counter, is high for the first half of each second and low for the rest.

Crystal error is trimmed without an adder in the counting path. One oscillator cycle shifts a second by roughly 30 ppm, which is too coarse on its own. So the correction is applied in only two of every sixty seconds, the ones with index 29 and 59. In those seconds the counter is loaded with a precomputed length of NOMINAL + cal - 1 cycles. Averaged over 30 seconds, this gives a resolution of about 1 ppm.

The calibration word is a plain 14-bit two's-complement input. A value of 1 means no correction. The length for a trimmed second is prepared in a register every cycle, so the counter itself only ever loads a value or decrements.

Top module: `spg_second_gen`

## Requirements
- R1: On reset, sec_idx is 0, sec_tick is low and sec_wave is high, and the first sec_tick comes in the NOMINAL-th cycle after reset is released.
- R2: Every second whose index is neither SECS/2-1 nor SECS-1 lasts exactly NOMINAL oscillator cycles, measured from the cycle after one sec_tick up to and including the next.
- R3: sec_idx holds its value during a second, steps by one after each sec_tick, and returns to 0 after the sec_tick of second SECS-1. It never exceeds SECS-1.
- R4: The seconds with index SECS/2-1 and SECS-1 (29 and 59 by default) last NOMINAL + cal - 1 cycles. cal is read as a signed 14-bit two's-complement value, so cal = 1 leaves the length at NOMINAL.
- R5: When NOMINAL + cal - 1 is below 2, a trimmed second lasts exactly 2 cycles.
- R6: A trimmed second uses the cal value present two clock edges before that second starts. A change of cal during a trimmed second has no effect on its length, but does apply to the next trimmed second.
- R7: In a second of L cycles, sec_wave is high for the first ceil(L/2) cycles and low for the remaining floor(L/2) cycles. This gives 50% duty for the even nominal length.
- R8: sec_tick is high for exactly one cycle per second, in the last cycle of that second, while sec_idx still shows that second's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cal | input | CAL_W | Signed calibration word, applied as cal - 1 cycles in trimmed seconds |
| sec_tick | output | 1 | One-cycle pulse in the last cycle of each second |
| sec_wave | output | 1 | 1 Hz square wave, high in the first half of each second |
| sec_idx | output | IDX_W | Index of the current second, 0 to SECS-1 |

## Verification
The bench sweeps the calibration word across several values: the no-correction value 1, small positive and negative trims, zero, and both 14-bit extremes. The most negative values drive the trimmed length into the 2-cycle floor. A design that ignored the sign bit would stretch a second instead of shortening it. A design that trimmed the wrong seconds, or trimmed every second, would show lengths off by one nominal pattern.

The bench also changes cal in the middle of second 29. A design that read cal continuously would give that second a mixed length, and one that latched too early would give second 59 the stale value.

Two further checks target the wave and the reset. The wave is counted high-cycle by high-cycle on odd trimmed lengths, where an off-by-one split of the second shows up directly. A reset in mid-second must restart both the index and the full nominal count.

// File: rtl/spg_pkg.sv
package spg_pkg;

    // Shortest second the counter can produce: the one reload cycle plus the one tick cycle.
    localparam int MIN_LEN = 2;

    // Kind of second about to begin.
    typedef enum logic {
        KIND_PLAIN = 1'b0,
        KIND_TRIM  = 1'b1
    } sec_kind_e;

    // Length in oscillator cycles of a trimmed second, with a floor at MIN_LEN.
    function automatic int trim_length(input int nominal, input int cal);
        int t;
        t = nominal + cal - 1;
        return (t < MIN_LEN) ? MIN_LEN : t;
    endfunction

endpackage

// File: rtl/spg_trim_reg.sv
module spg_trim_reg #(
    parameter int NOMINAL = 32768,
    parameter int CAL_W   = 14,
    parameter int CNT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [CAL_W-1:0] cal,
    output logic [CNT_W-1:0]        trim_len
);
    import spg_pkg::*;

    // The trimmed length is prepared here, one register ahead of the counter,
    // so that the counter only ever loads or decrements.
    always_ff @(posedge clk) begin
        if (rst) begin
            trim_len <= CNT_W'(NOMINAL);
        end else begin
            trim_len <= CNT_W'(trim_length(NOMINAL, int'(cal)));
        end
    end

    // R5: a prepared length is never below the floor
    p_trim_floor_r5: assert property (@(posedge clk) disable iff (rst)
        trim_len >= CNT_W'(MIN_LEN));

endmodule

// File: rtl/spg_sec_index.sv
module spg_sec_index #(
    parameter int SECS   = 60,
    parameter int COMP_A = 29,
    parameter int COMP_B = 59,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [IDX_W-1:0]  idx,
    output spg_pkg::sec_kind_e next_kind
);
    import spg_pkg::*;

    logic [IDX_W-1:0] idx_next;

    always_comb begin
        idx_next  = (idx == IDX_W'(SECS - 1)) ? '0 : idx + 1'b1;
        next_kind = (idx_next == IDX_W'(COMP_A) || idx_next == IDX_W'(COMP_B)) ? KIND_TRIM : KIND_PLAIN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (tick) begin
            idx <= idx_next;
        end
    end

    // R3: the index stays within its range
    p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_W'(SECS - 1));

    // R3: the index holds between ticks
    p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(idx));

    // R3: the index wraps after the last second
    p_idx_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && idx == IDX_W'(SECS - 1)) |=> idx == '0);

    // R3: the index steps by one otherwise
    p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && idx != IDX_W'(SECS - 1)) |=> idx == $past(idx) + 1'b1);

endmodule

// File: rtl/spg_down_counter.sv
module spg_down_counter #(
    parameter int NOMINAL = 32768,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  spg_pkg::sec_kind_e load_kind,
    input  logic [CNT_W-1:0]   trim_len,
    output logic               tick,
    output logic               wave
);
    import spg_pkg::*;

    logic [CNT_W-1:0] cnt;       // cycles left in this second, minus one
    logic [CNT_W-1:0] half;      // wave falls once cnt drops below this
    logic [CNT_W-1:0] load_len;

    always_comb begin
        load_len = (load_kind == KIND_TRIM) ? trim_len : CNT_W'(NOMINAL);
        tick     = (cnt == '0);
        wave     = (cnt >= half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= CNT_W'(NOMINAL - 1);
            half <= CNT_W'(NOMINAL / 2);
        end else if (tick) begin
            cnt  <= load_len - 1'b1;
            half <= load_len >> 1;
        end else begin
            cnt  <= cnt - 1'b1;
        end
    end

    // R8: the tick never lasts two cycles
    p_tick_single_r8: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R2: between ticks the counter decrements by one
    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> cnt == $past(cnt) - 1'b1);

    // R7: each second starts with the wave high
    p_wave_rise_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> wave);

    // R7: the wave is low in the tick cycle
    p_wave_low_at_tick_r7: assert property (@(posedge clk) disable iff (rst)
        tick |-> !wave);

endmodule

// File: rtl/spg_second_gen.sv
module spg_second_gen #(
    parameter  int NOMINAL = 32768,
    parameter  int CAL_W   = 14,
    parameter  int SECS    = 60,
    localparam int IDX_W   = $clog2(SECS),
    localparam int CNT_W   = $clog2(NOMINAL + (1 << (CAL_W - 1)) + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [CAL_W-1:0] cal,
    output logic                    sec_tick,
    output logic                    sec_wave,
    output logic [IDX_W-1:0]        sec_idx
);
    import spg_pkg::*;

    localparam int COMP_A = SECS / 2 - 1;
    localparam int COMP_B = SECS - 1;

    logic [CNT_W-1:0] trim_len;
    sec_kind_e        next_kind;

    spg_trim_reg #(
        .NOMINAL (NOMINAL),
        .CAL_W   (CAL_W),
        .CNT_W   (CNT_W)
    ) u_trim (
        .clk      (clk),
        .rst      (rst),
        .cal      (cal),
        .trim_len (trim_len)
    );

    spg_sec_index #(
        .SECS   (SECS),
        .COMP_A (COMP_A),
        .COMP_B (COMP_B),
        .IDX_W  (IDX_W)
    ) u_index (
        .clk       (clk),
        .rst       (rst),
        .tick      (sec_tick),
        .idx       (sec_idx),
        .next_kind (next_kind)
    );

    spg_down_counter #(
        .NOMINAL (NOMINAL),
        .CNT_W   (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .load_kind (next_kind),
        .trim_len  (trim_len),
        .tick      (sec_tick),
        .wave      (sec_wave)
    );

    // R8: a tick in the last second returns the index to zero
    p_tick_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && sec_idx == IDX_W'(SECS - 1)) |=> (sec_idx == '0 && !sec_tick));

endmodule

// File: tb/tb_spg_second_gen.sv
module tb_spg_second_gen;

    localparam int NOM   = 16;
    localparam int SECS  = 60;
    localparam int NVEC  = 7;

    // Vector table: calibration word and the trimmed length it must produce.
    localparam logic [13:0] CAL_V   [0:NVEC-1] = '{14'd1, 14'd5, 14'h3FFD, 14'd0, 14'h3FEC, 14'h1FFF, 14'h2000};
    localparam int          EXP_LEN [0:NVEC-1] = '{16, 20, 12, 15, 2, 8206, 2};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] cal = 14'd1;
    logic        tick;
    logic        wave;
    logic [5:0]  sidx;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    spg_second_gen #(.NOMINAL(NOM), .CAL_W(14), .SECS(SECS)) dut (
        .clk      (clk),
        .rst      (rst),
        .cal      (cal),
        .sec_tick (tick),
        .sec_wave (wave),
        .sec_idx  (sidx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts one second starting at the current negedge, up to and including the tick cycle.
    task automatic measure(input int chg_at, input logic [13:0] chg_val,
                           output int len, output int hi, output int idx);
        len = 0;
        hi  = 0;
        idx = -1;
        forever begin
            len++;
            if (wave) hi++;
            if (len == chg_at) cal = chg_val;
            if (tick) begin
                idx = int'(sidx);
                break;
            end
            if (len > 20000) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        fails++;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int len, hi, idx, exp;
        string req;

        do_reset();
        // R1: reset state
        chk(sidx == 6'd0, "R1 idx", int'(sidx), 0);
        chk(tick == 1'b0, "R1 tick", int'(tick), 0);
        chk(wave == 1'b1, "R1 wave", int'(wave), 1);

        // Vector table: one full minute per calibration word
        for (int v = 0; v < NVEC; v++) begin
            cal = CAL_V[v];
            for (int s = 0; s < SECS; s++) begin
                measure(-1, 14'd0, len, hi, idx);
                if (s == 29 || s == 59) begin
                    exp = EXP_LEN[v];
                    req = (exp == 2) ? "R5 trimmed length floor" : "R4 trimmed length";
                end else begin
                    exp = NOM;
                    req = (v == 0 && s == 0) ? "R1 first second" : "R2 plain length";
                end
                chk(len == exp, req, len, exp);
                chk(idx == s, "R3 index at tick", idx, s);
                chk(hi == (exp + 1) / 2, "R7 wave high cycles", hi, (exp + 1) / 2);
                chk(tick == 1'b0, "R8 tick width", int'(tick), 0);
            end
        end

        // R6: change cal inside second 29; it must keep its length, second 59 takes the new value
        cal = 14'd5;
        for (int s = 0; s < SECS; s++) begin
            if (s == 29) begin
                measure(3, 14'd100, len, hi, idx);
                chk(len == 20, "R6 change inside trimmed second", len, 20);
            end else begin
                measure(-1, 14'd0, len, hi, idx);
                if (s == 59) chk(len == 115, "R6 new cal at next trimmed second", len, 115);
                else chk(len == NOM, "R2 plain length", len, NOM);
            end
            chk(idx == s, "R3 index at tick", idx, s);
        end

        // R1: reset in mid-second restarts index and count
        cal = 14'd1;
        repeat (5) measure(-1, 14'd0, len, hi, idx);
        repeat (7) @(negedge clk);
        do_reset();
        chk(sidx == 6'd0, "R1 idx after mid reset", int'(sidx), 0);
        chk(wave == 1'b1, "R1 wave after mid reset", int'(wave), 1);
        measure(-1, 14'd0, len, hi, idx);
        chk(len == NOM, "R1 first second after reset", len, NOM);
        chk(idx == 0, "R3 index after reset", idx, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule